// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block chooses which pending interrupt a small 8-bit microcontroller core takes next, and then carries out the entry sequence. It holds a 32-bit pending register that peripherals set through strobe bits, plus one reset-request latch. When the core's global interrupt enable is high and no instruction skip is outstanding, the block accepts one request. It stores the return word address on the stack one byte per cycle through a byte-wide write port, with the stack pointer moving down after each byte. In the final cycle it presents the vector address and the updated stack pointer to the core, and asks the core to clear its global interrupt flag.

The core stalls while `busy_o` is high. In the cycle where `done_o` pulses it loads the new program counter and stack pointer. Two strap inputs are sampled at acceptance. The first sets how many return-address bytes are pushed. The second sets whether a vector slot is one word or two.

Top module: `irq_entry_seq`

## Requirements
- R1: No request is accepted while `skip_i` is high. The block stays idle and makes no stack write until `skip_i` falls.
- R2: A latched reset request takes precedence over every pending source and uses vector number 0. It is accepted only while `gie_i` is high, and accepting it leaves the pending register unchanged.
- R3: Among the pending sources, the lowest set bit index wins. Its vector number is that index plus one.
- R4: `pc_new_o` equals the vector number times the slot size. The slot size is 2 words when `long_vec_i`=1 and 1 word when `long_vec_i`=0, with base address 0.
- R5: Writes begin in the cycle after acceptance, one byte per cycle, least significant return-PC byte first. The k-th write (k from 0) goes to address SP−k. `sp_new_o` equals SP minus the byte count, modulo 2^16.
- R6: The byte count depends on `pc_mode_i`: 1 gives 2 bytes, 2 gives 3 bytes, and 0 or 3 give 1 byte.
- R7: `busy_o` is high from the first write through the closing cycle. In the cycle after the last write, `done_o`, `pc_load_o`, `sp_load_o` and `gie_clr_o` all pulse for exactly one cycle. After reset, all outputs are idle and the pending state is empty.
- R8: Each `src_set_i` bit ORs into the pending register (`pend_o`). The serviced bit is cleared at acceptance. If a set and the clear hit the same bit in the same cycle, the set wins. `irq_o` is high whenever any pending bit is set.
- R9: No request is accepted while `gie_i` is low or while a sequence is running. A request that arrives mid-sequence is held and taken only after the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req_i | input | 1 | Strobe that latches a reset request |
| src_set_i | input | 32 | Per-source pending set strobes |
| gie_i | input | 1 | Global interrupt enable from the core |
| skip_i | input | 1 | Core has an instruction skip outstanding |
| pc_i | input | 22 | Current word program counter (return address) |
| sp_i | input | 16 | Current stack pointer |
| pc_mode_i | input | 2 | Return address byte count select |
| long_vec_i | input | 1 | Two-word vector slots when high |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | 16 | Stack byte write address |
| mem_wdata_o | output | 8 | Stack byte write data |
| busy_o | output | 1 | Entry sequence in progress, core stalls |
| done_o | output | 1 | One-cycle completion pulse |
| pc_load_o | output | 1 | Core loads `pc_new_o` |
| pc_new_o | output | 22 | Vector word address |
| sp_load_o | output | 1 | Core loads `sp_new_o` |
| sp_new_o | output | 16 | Stack pointer after the push |
| gie_clr_o | output | 1 | Core clears its global interrupt flag |
| irq_o | output | 1 | Any source pending |
| pend_o | output | 32 | Pending register contents |

## Verification
Two cases are hard to reach from the ports. The first is a new request that arrives while bytes are still being pushed. The stimulus injects a higher-priority strobe at the first busy cycle, then checks that the current vector is unchanged and that the new source is taken next. The second is a set strobe that lands on the same edge that retires that bit. The stimulus raises the enable and re-strobes the already pending bit in the same cycle, so acceptance and the set coincide. A table of mixed reset and multi-bit pending patterns, including stack pointer wrap at zero, drains each pattern one source at a time to confirm the service order.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PUSH   = 2'd1,
        ST_VECTOR = 2'd2
    } seq_state_e;

    // index of the last byte to push for a given width strap
    function automatic logic [1:0] last_byte_idx(input logic [1:0] mode);
        case (mode)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    // lowest set bit must be chosen: chosen bit set, nothing below it set
    always_comb begin
        if (any_o) begin
            p_pick_lowest_r3: assert (req_i[idx_o] &&
                ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int VEC_W = 6,
    parameter int PC_W  = 22
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic             long_slot_i,
    output logic [PC_W-1:0]  addr_o
);
    logic [PC_W-1:0] vec_ext;

    always_comb begin
        vec_ext = PC_W'(vec_i);
        addr_o  = long_slot_i ? (vec_ext << 1) : vec_ext;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int SRC_N = 32,
    parameter int PC_W  = 22,
    parameter int SP_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req_i,
    input  logic [SRC_N-1:0] src_set_i,
    input  logic             gie_i,
    input  logic             skip_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [SP_W-1:0]  sp_i,
    input  logic [1:0]       pc_mode_i,
    input  logic             long_vec_i,
    output logic             mem_we_o,
    output logic [SP_W-1:0]  mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  pc_new_o,
    output logic             sp_load_o,
    output logic [SP_W-1:0]  sp_new_o,
    output logic             gie_clr_o,
    output logic             irq_o,
    output logic [SRC_N-1:0] pend_o
);
    localparam int IDX_W = $clog2(SRC_N);
    localparam int VEC_W = $clog2(SRC_N + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [SRC_N-1:0] pend;
        logic             rst_pend;
        logic [PC_W-1:0]  ret_pc;
        logic [SP_W-1:0]  sp;
        logic [1:0]       cnt;
        logic [1:0]       last;
        logic [VEC_W-1:0] vec;
        logic             long_slot;
    } seq_regs_t;

    seq_regs_t q, d;

    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             take_rst, take_hw, can_take;
    logic [SRC_N-1:0] clr_mask;

    irq_pick #(.N(SRC_N), .IDX_W(IDX_W)) u_pick (
        .req_i (q.pend),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    irq_vec_addr #(.VEC_W(VEC_W), .PC_W(PC_W)) u_vec (
        .vec_i       (q.vec),
        .long_slot_i (q.long_slot),
        .addr_o      (pc_new_o)
    );

    always_comb begin
        d        = q;
        can_take = (q.st == ST_IDLE) && gie_i && !skip_i;
        take_rst = can_take && q.rst_pend;
        take_hw  = can_take && !q.rst_pend && pick_any;
        clr_mask = take_hw ? (SRC_N'(1) << pick_idx) : '0;

        d.pend     = (q.pend & ~clr_mask) | src_set_i;
        d.rst_pend = (q.rst_pend & ~take_rst) | rst_req_i;

        case (q.st)
            ST_IDLE: begin
                if (take_rst || take_hw) begin
                    d.st        = ST_PUSH;
                    d.ret_pc    = pc_i;
                    d.sp        = sp_i;
                    d.cnt       = '0;
                    d.last      = last_byte_idx(pc_mode_i);
                    d.vec       = take_rst ? '0 : (VEC_W'(pick_idx) + VEC_W'(1));
                    d.long_slot = long_vec_i;
                end
            end
            ST_PUSH: begin
                d.sp  = q.sp - SP_W'(1);
                d.cnt = q.cnt + 2'd1;
                if (q.cnt == q.last) d.st = ST_VECTOR;
            end
            ST_VECTOR: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_we_o    = (q.st == ST_PUSH);
        mem_addr_o  = q.sp;
        mem_wdata_o = 8'(q.ret_pc >> {q.cnt, 3'b000});
        busy_o      = (q.st != ST_IDLE);
        done_o      = (q.st == ST_VECTOR);
        pc_load_o   = done_o;
        sp_load_o   = done_o;
        gie_clr_o   = done_o;
        sp_new_o    = q.sp;
        irq_o       = |q.pend;
        pend_o      = q.pend;
    end

    p_skip_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && skip_i) |=> (q.st == ST_IDLE));

    p_rst_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && gie_i && !skip_i && q.rst_pend) |=> (q.vec == '0));

    p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - SP_W'(1)));

    p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (q.cnt <= 2'd2));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_starts_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> mem_we_o);

    p_gie_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !gie_i) |=> (q.st == ST_IDLE));
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req_i = 1'b0;
    logic [31:0] src_set_i = '0;
    logic        gie_i = 1'b0;
    logic        skip_i = 1'b0;
    logic [21:0] pc_i = '0;
    logic [15:0] sp_i = '0;
    logic [1:0]  pc_mode_i = '0;
    logic        long_vec_i = 1'b0;
    logic        mem_we_o, busy_o, done_o, pc_load_o, sp_load_o, gie_clr_o, irq_o;
    logic [15:0] mem_addr_o, sp_new_o;
    logic [7:0]  mem_wdata_o;
    logic [21:0] pc_new_o;
    logic [31:0] pend_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .src_set_i(src_set_i),
        .gie_i(gie_i), .skip_i(skip_i), .pc_i(pc_i), .sp_i(sp_i),
        .pc_mode_i(pc_mode_i), .long_vec_i(long_vec_i),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .busy_o(busy_o), .done_o(done_o), .pc_load_o(pc_load_o), .pc_new_o(pc_new_o),
        .sp_load_o(sp_load_o), .sp_new_o(sp_new_o), .gie_clr_o(gie_clr_o),
        .irq_o(irq_o), .pend_o(pend_o)
    );

    typedef struct packed {
        logic [31:0] mask;
        logic        rst;
        logic [1:0]  mode;
        logic        lng;
        logic [21:0] pc;
        logic [15:0] sp;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{32'h0000_0001, 1'b0, 2'd0, 1'b0, 22'h0000AB, 16'h08FF},
        '{32'h8000_0000, 1'b0, 2'd1, 1'b1, 22'h001234, 16'h10FF},
        '{32'h0001_0110, 1'b0, 2'd2, 1'b1, 22'h3A5C71, 16'h21FF},
        '{32'h0000_0000, 1'b1, 2'd1, 1'b0, 22'h000456, 16'h0100},
        '{32'h0000_0C00, 1'b1, 2'd2, 1'b1, 22'h2BCDEF, 16'h0002},
        '{32'hFFFF_FFFF, 1'b0, 2'd3, 1'b0, 22'h00007E, 16'h0000}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic pulse(input logic [31:0] mask, input logic rq);
        @(negedge clk);
        src_set_i = mask;
        rst_req_i = rq;
        @(negedge clk);
        src_set_i = '0;
        rst_req_i = 1'b0;
    endtask

    task automatic service(input logic [21:0] pc, input logic [15:0] sp,
                           input logic [1:0] mode, input logic lng,
                           input int vec, input string tag,
                           input logic [31:0] start_mask, input logic [31:0] mid_mask,
                           input logic [31:0] exp_pend, output logic [15:0] sp_after);
        int n, k, guard;
        bit injected;
        n = (mode == 2'd1) ? 2 : (mode == 2'd2) ? 3 : 1;
        pc_i = pc; sp_i = sp; pc_mode_i = mode; long_vec_i = lng;
        gie_i = 1'b1;
        src_set_i = start_mask;
        k = 0; guard = 0; injected = 0;
        forever begin
            @(negedge clk);
            src_set_i = '0;
            if (mid_mask != 0 && busy_o && !injected) begin
                src_set_i = mid_mask;
                injected = 1;
            end
            if (mem_we_o) begin
                chk(mem_addr_o == 16'(sp - 16'(k)), "R5 addr", mem_addr_o, 16'(sp - 16'(k)));
                chk(mem_wdata_o == 8'(pc >> (8 * k)), "R5 data", mem_wdata_o, 8'(pc >> (8 * k)));
                k++;
            end
            if (done_o) break;
            guard++;
            if (guard > 40) begin
                chk(1'b0, "R7 done missing", 0, 1);
                break;
            end
        end
        chk(k == n, "R6 byte count", k, n);
        chk(pc_new_o == 22'(vec * (lng ? 2 : 1)), tag, pc_new_o, 22'(vec * (lng ? 2 : 1)));
        chk(pc_new_o == 22'(vec * (lng ? 2 : 1)), "R4 vector addr", pc_new_o, 22'(vec * (lng ? 2 : 1)));
        chk(sp_new_o == 16'(sp - 16'(n)), "R5 final sp", sp_new_o, 16'(sp - 16'(n)));
        chk(pc_load_o && sp_load_o && gie_clr_o && busy_o, "R7 closing strobes",
            {pc_load_o, sp_load_o, gie_clr_o, busy_o}, 4'hF);
        sp_after = sp_new_o;
        gie_i = 1'b0;
        src_set_i = '0;
        @(negedge clk);
        chk(!busy_o && !done_o, "R7 return idle", {busy_o, done_o}, 0);
        chk(pend_o == exp_pend, "R8 pending", pend_o, exp_pend);
        chk(irq_o == (exp_pend != 0), "R8 irq level", irq_o, exp_pend != 0);
    endtask

    initial begin
        logic [15:0] sp_cur;
        logic [31:0] pend;
        logic        rq;
        bit          seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 style reset state is covered by R7
        chk(!busy_o && !mem_we_o && !done_o && !gie_clr_o, "R7 reset outputs",
            {busy_o, mem_we_o, done_o, gie_clr_o}, 0);
        chk(pend_o == 0 && !irq_o, "R8 reset pending", pend_o, 0);

        // table of patterns, each drained one source at a time
        foreach (ROWS[r]) begin
            pend = ROWS[r].mask;
            rq = ROWS[r].rst;
            pulse(ROWS[r].mask, ROWS[r].rst);
            chk(pend_o == pend, "R8 set strobes", pend_o, pend);
            sp_cur = ROWS[r].sp;
            while (rq || pend != 0) begin
                if (rq) begin
                    rq = 1'b0;
                    service(ROWS[r].pc, sp_cur, ROWS[r].mode, ROWS[r].lng, 0, "R2 reset vector",
                            '0, '0, pend, sp_cur);
                end else begin
                    int b;
                    b = lowest(pend);
                    pend = pend & ~(32'h1 << b);
                    service(ROWS[r].pc, sp_cur, ROWS[r].mode, ROWS[r].lng, b + 1, "R3 priority",
                            '0, '0, pend, sp_cur);
                end
            end
        end

        // R1: skip outstanding holds off entry
        skip_i = 1'b1;
        gie_i = 1'b1;
        pulse(32'h1 << 5, 1'b0);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            seen = seen | busy_o | mem_we_o;
        end
        chk(!seen, "R1 skip blocks", seen, 0);
        skip_i = 1'b0;
        gie_i = 1'b0;
        service(22'h000321, 16'h0400, 2'd1, 1'b0, 6, "R1 entry after skip", '0, '0, '0, sp_cur);

        // R9 and R2: reset request with enable low waits
        pulse('0, 1'b1);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            seen = seen | busy_o | mem_we_o;
        end
        chk(!seen, "R9 enable low blocks", seen, 0);
        service(22'h000777, 16'h0300, 2'd0, 1'b1, 0, "R2 reset after enable", '0, '0, '0, sp_cur);

        // R9: higher priority arrival mid-sequence waits
        pulse(32'h1 << 9, 1'b0);
        service(22'h012345, 16'h0500, 2'd2, 1'b0, 10, "R9 current vector kept",
                '0, 32'h1 << 2, 32'h1 << 2, sp_cur);
        service(22'h012345, sp_cur, 2'd2, 1'b0, 3, "R9 held request taken", '0, '0, '0, sp_cur);

        // R8: set and retire of the same bit on one edge, set wins
        pulse(32'h1 << 7, 1'b0);
        service(22'h000042, 16'h0600, 2'd1, 1'b1, 8, "R8 first service",
                32'h1 << 7, '0, 32'h1 << 7, sp_cur);
        service(22'h000042, sp_cur, 2'd1, 1'b1, 8, "R8 second service", '0, '0, '0, sp_cur);

        summary();
        $finish;
    end
endmodule